// File: doc/BRIEF.md
# Cascadable Dual 8-bit Compare Timer

Two independent 8-bit up-counters sit behind one byte-addressed register file. Each channel advances on a count-enable from its own prescaler. It compares its count against two match values and can reload zero on either match. It pulses three interrupt lines, one each for match A, match B and wrap-around. Software sets up a channel by writing its control, compare and clock-control registers. Counting starts when the clock source field selects the internal clock and the prescaler field is non-zero.

Channel 0 can also take the cascade source. The two counters then act as one 16-bit counter: channel 0 is the high byte and channel 1 the low byte. The pair is clocked by channel 1's prescaler and compared against the 16-bit values built from both channels' compare registers. The bus accepts byte accesses to any register. It accepts 16-bit accesses to the compare, counter and clock-control pairs, which move both channels at once with channel 0 in the upper byte.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset both counters read 0x00, all compare registers 0xFF, control and clock-control 0x00, channel 0 status 0x00 and channel 1 status 0x10. Register index is bus_addr[3:1] (0 control, 1 status, 2 compare A, 3 compare B, 4 counter, 5 clock control) and bus_addr[0] selects the channel.
- R2: A byte read returns {8'h00, value} on bus_rdata in the cycle after the request. Control reads back bits 7:3, clock control reads back bits 7 and 4:0, channel 0 status reads back bits 5:0, and channel 1 status reads back bits 3:0 with bits 5:4 fixed at 01. All other bits and indices 6 and 7 read as 0.
- R3: A 16-bit access at an even address to index 2 to 5 writes bus_wdata[15:8] to channel 0 and bus_wdata[7:0] to channel 1, and reads back in the same arrangement.
- R4: A 16-bit access at an odd address, or to index 0, 1, 6 or 7, reads 16'hFFFF and a write of that kind changes nothing.
- R5: Clock-control bits 2:0 select one count-enable every 1, 2, 8, 32, 64, 1024 or 8192 cycles for values 1 to 7; value 0 stops the channel. A write to clock control restarts the divider, so the first enable comes in the cycle after the write.
- R6: On a count-enable where the counter equals compare A (or B), irq_cmpa (irq_cmpb) pulses high for the next cycle if control bit 6 (bit 7) is set, and stays low otherwise.
- R7: Control bits 4:3 select clearing. With 1, a count-enable at count == compare A loads 0 instead of incrementing. With 2, the same holds for compare B. Values 0 and 3 never clear.
- R8: A count-enable at count 0xFF wraps to 0, and irq_ovf pulses for the next cycle if control bit 5 is set.
- R9: When channel 0's source field (clock control bits 4:3) is 3, {counter0, counter1} counts as 16 bits on channel 1's enables. It compares against {cmpA0, cmpA1} and {cmpB0, cmpB1} and overflows at 0xFFFF. Channel 0's control governs clearing and enables, the pulses appear on the channel 0 outputs, and the channel 1 outputs stay low.
- R10: A channel whose source field is 0, 2, or 3 (outside cascade on channel 0) holds its count.
- R11: A bus write to a counter byte takes effect over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_wide | input | 1 | 1 for a 16-bit access |
| bus_addr | input | 4 | Register index [3:1] and channel [0] |
| bus_wdata | input | 16 | Write data (byte accesses use [7:0]) |
| bus_rdata | output | 16 | Registered read data |
| irq_cmpa | output | 2 | Match A pulse per channel |
| irq_cmpb | output | 2 | Match B pulse per channel |
| irq_ovf | output | 2 | Wrap-around pulse per channel |

## Verification
A wrong divider phase or a counter that is off by one shifts every interrupt pulse and every counter read-back. The reference model flags this on the first compared cycle after the mismatch appears. A cascade or clear-mode fault changes the pulse period itself, which the pulse-count windows catch after one period of the programmed compare value. A decode fault shows on the very next read of the register it corrupted.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int NCH    = 2;
  localparam int ADDR_W = 4;
  localparam int PRE_W  = 13;

  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_STAT = 3'd1;
  localparam logic [2:0] RG_CMPA = 3'd2;
  localparam logic [2:0] RG_CMPB = 3'd3;
  localparam logic [2:0] RG_CNT  = 3'd4;
  localparam logic [2:0] RG_CLK  = 3'd5;

  localparam logic [1:0] SRC_INT  = 2'd1;
  localparam logic [1:0] SRC_CASC = 2'd3;
  localparam logic [1:0] CLR_A    = 2'd1;
  localparam logic [1:0] CLR_B    = 2'd2;

  // control byte bits 7:3
  typedef struct packed {
    logic       ie_b;
    logic       ie_a;
    logic       ie_ovf;
    logic [1:0] clr;
  } ctrl_t;

  // clock-control byte bits 7 and 4:0
  typedef struct packed {
    logic       keep7;
    logic [1:0] src;
    logic [2:0] psel;
  } clkc_t;

  // log2 of the divisor chosen by a prescaler select value
  function automatic int unsigned psel_shift(input logic [2:0] s);
    case (s)
      3'd2:    return 1;
      3'd3:    return 3;
      3'd4:    return 5;
      3'd5:    return 6;
      3'd6:    return 10;
      3'd7:    return 13;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dct_pkg::*;
#(
  parameter int CNT_W = PRE_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic [2:0] psel,
  output logic       tick
);
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] mask;

  always_ff @(posedge clk) begin
    if (rst || restart) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  always_comb begin
    mask = (CNT_W'(1) << psel_shift(psel)) - CNT_W'(1);
    tick = (psel != 3'd0) && ((div_q & mask) == '0);
  end
endmodule

// File: rtl/dct_step.sv
module dct_step
  import dct_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         run,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmpa,
  input  logic [W-1:0] cmpb,
  input  logic [1:0]   clr,
  output logic [W-1:0] nxt,
  output logic         hit_a,
  output logic         hit_b,
  output logic         wrap
);
  logic eq_a, eq_b;

  always_comb begin
    eq_a  = (cnt == cmpa);
    eq_b  = (cnt == cmpb);
    hit_a = run && eq_a;
    hit_b = run && eq_b;
    wrap  = run && (&cnt);
    nxt   = cnt;
    if (run) begin
      if ((clr == CLR_A && eq_a) || (clr == CLR_B && eq_b)) nxt = '0;
      else                                                  nxt = cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [BYTE_W-1:0] cnt_q   [NCH],
  output ctrl_t             ctrl_q  [NCH],
  output clkc_t             clkc_q  [NCH],
  output logic [BYTE_W-1:0] cmpa_q  [NCH],
  output logic [BYTE_W-1:0] cmpb_q  [NCH],
  output logic [NCH-1:0]    cnt_we,
  output logic [BYTE_W-1:0] cnt_wd  [NCH],
  output logic [NCH-1:0]    clk_we
);
  logic [2:0]        ridx;
  logic              chan;
  logic              wide_ok;
  logic              wide_bad;
  logic [NCH-1:0]    lane_we;
  logic [BYTE_W-1:0] lane_wd [NCH];
  logic [BYTE_W-1:0] view    [NCH];

  assign ridx     = bus_addr[3:1];
  assign chan     = bus_addr[0];
  assign wide_ok  = !chan && (ridx inside {RG_CMPA, RG_CMPB, RG_CNT, RG_CLK});
  assign wide_bad = bus_wide && !wide_ok;

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    localparam int HI = (NCH - 1 - g) * BYTE_W;
    localparam logic [5:0] STAT_RST  = (g == 0) ? 6'h00 : 6'h10;
    localparam logic [5:0] STAT_KEEP = (g == 0) ? 6'h3F : 6'h0F;

    ctrl_t             c_q;
    clkc_t             k_q;
    logic [BYTE_W-1:0] a_q, b_q;
    logic [5:0]        s_q;

    assign lane_we[g] = bus_sel && bus_wr && !wide_bad && (bus_wide || chan == 1'(g));
    assign lane_wd[g] = bus_wide ? bus_wdata[HI +: BYTE_W] : bus_wdata[BYTE_W-1:0];
    assign cnt_we[g]  = lane_we[g] && (ridx == RG_CNT);
    assign clk_we[g]  = lane_we[g] && (ridx == RG_CLK);
    assign cnt_wd[g]  = lane_wd[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        c_q <= '0;
        k_q <= '0;
        a_q <= '1;
        b_q <= '1;
        s_q <= STAT_RST;
      end else if (lane_we[g]) begin
        case (ridx)
          RG_CTRL: c_q <= ctrl_t'(lane_wd[g][7:3]);
          RG_STAT: s_q <= (lane_wd[g][5:0] & STAT_KEEP) | (STAT_RST & ~STAT_KEEP);
          RG_CMPA: a_q <= lane_wd[g];
          RG_CMPB: b_q <= lane_wd[g];
          RG_CLK:  k_q <= clkc_t'({lane_wd[g][7], lane_wd[g][4:0]});
          default: ;
        endcase
      end
    end

    assign ctrl_q[g] = c_q;
    assign clkc_q[g] = k_q;
    assign cmpa_q[g] = a_q;
    assign cmpb_q[g] = b_q;

    always_comb begin
      case (ridx)
        RG_CTRL: view[g] = {c_q, 3'b000};
        RG_STAT: view[g] = {2'b00, s_q};
        RG_CMPA: view[g] = a_q;
        RG_CMPB: view[g] = b_q;
        RG_CNT:  view[g] = cnt_q[g];
        RG_CLK:  view[g] = {k_q.keep7, 2'b00, k_q.src, k_q.psel};
        default: view[g] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_sel && !bus_wr) begin
      if (wide_bad)      bus_rdata <= '1;
      else if (bus_wide) bus_rdata <= {view[0], view[1]};
      else               bus_rdata <= {{BYTE_W{1'b0}}, view[chan]};
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter int DIV_W = PRE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_wide,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [NCH-1:0]    irq_cmpa,
  output logic [NCH-1:0]    irq_cmpb,
  output logic [NCH-1:0]    irq_ovf
);
  ctrl_t             ctrl_q [NCH];
  clkc_t             clkc_q [NCH];
  logic [BYTE_W-1:0] cmpa_q [NCH];
  logic [BYTE_W-1:0] cmpb_q [NCH];
  logic [BYTE_W-1:0] cnt_q  [NCH];
  logic [BYTE_W-1:0] cnt_wd [NCH];
  logic [BYTE_W-1:0] nxt8   [NCH];
  logic [NCH-1:0]    cnt_we, clk_we, tick, run, ha, hb, wr8;
  logic              casc;
  logic [WORD_W-1:0] nxt16;
  logic              h16a, h16b, w16;

  dct_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_wide (bus_wide),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .cnt_q    (cnt_q),
    .ctrl_q   (ctrl_q),
    .clkc_q   (clkc_q),
    .cmpa_q   (cmpa_q),
    .cmpb_q   (cmpb_q),
    .cnt_we   (cnt_we),
    .cnt_wd   (cnt_wd),
    .clk_we   (clk_we)
  );

  assign casc = (clkc_q[0].src == SRC_CASC);

  // joined counter: high byte channel 0, clocked by the last channel
  dct_step #(.W(WORD_W)) u_step16 (
    .run  (run[NCH-1]),
    .cnt  ({cnt_q[0], cnt_q[1]}),
    .cmpa ({cmpa_q[0], cmpa_q[1]}),
    .cmpb ({cmpb_q[0], cmpb_q[1]}),
    .clr  (ctrl_q[0].clr),
    .nxt  (nxt16),
    .hit_a(h16a),
    .hit_b(h16b),
    .wrap (w16)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int HI = (NCH - 1 - g) * BYTE_W;
    logic [BYTE_W-1:0] c_q;
    logic              a_q, b_q, o_q;

    dct_prescaler #(.CNT_W(DIV_W)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .restart(clk_we[g]),
      .psel   (clkc_q[g].psel),
      .tick   (tick[g])
    );

    assign run[g] = (clkc_q[g].src == SRC_INT) && tick[g];

    dct_step #(.W(BYTE_W)) u_step (
      .run  (run[g]),
      .cnt  (c_q),
      .cmpa (cmpa_q[g]),
      .cmpb (cmpb_q[g]),
      .clr  (ctrl_q[g].clr),
      .nxt  (nxt8[g]),
      .hit_a(ha[g]),
      .hit_b(hb[g]),
      .wrap (wr8[g])
    );

    always_ff @(posedge clk) begin
      if (rst)            c_q <= '0;
      else if (cnt_we[g]) c_q <= cnt_wd[g];
      else if (casc)      c_q <= nxt16[HI +: BYTE_W];
      else                c_q <= nxt8[g];
    end
    assign cnt_q[g] = c_q;

    if (g == 0) begin : g_lead
      always_ff @(posedge clk) begin
        if (rst) begin
          a_q <= 1'b0;
          b_q <= 1'b0;
          o_q <= 1'b0;
        end else begin
          a_q <= ctrl_q[g].ie_a   && (casc ? h16a : ha[g]);
          b_q <= ctrl_q[g].ie_b   && (casc ? h16b : hb[g]);
          o_q <= ctrl_q[g].ie_ovf && (casc ? w16  : wr8[g]);
        end
      end
    end else begin : g_follow
      always_ff @(posedge clk) begin
        if (rst) begin
          a_q <= 1'b0;
          b_q <= 1'b0;
          o_q <= 1'b0;
        end else begin
          a_q <= !casc && ctrl_q[g].ie_a   && ha[g];
          b_q <= !casc && ctrl_q[g].ie_b   && hb[g];
          o_q <= !casc && ctrl_q[g].ie_ovf && wr8[g];
        end
      end
    end

    assign irq_cmpa[g] = a_q;
    assign irq_cmpb[g] = b_q;
    assign irq_ovf[g]  = o_q;
  end
endmodule

// File: rtl/dct_chk.sv
module dct_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic        bus_wide,
  input logic [3:0]  bus_addr,
  input logic [15:0] bus_rdata,
  input logic [1:0]  irq_cmpa,
  input logic [1:0]  irq_cmpb,
  input logic [1:0]  irq_ovf,
  input logic        casc,
  input logic        ie_a1,
  input logic        ie_b1,
  input logic [2:0]  psel0,
  input logic [7:0]  cnt0,
  input logic [7:0]  cnt1,
  input logic [1:0]  cnt_we
);
  // R4: odd-address wide read answers all ones
  a_r4_bad_wide_read: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_wr && bus_wide && bus_addr[0]) |=> (bus_rdata == 16'hFFFF));

  // R5: a stopped prescaler leaves the counter alone
  a_r5_stopped_holds: assert property (@(posedge clk) disable iff (rst)
    (!casc && psel0 == 3'd0 && !cnt_we[0]) |=> $stable(cnt0));

  // R6: match pulses need their enable
  a_r6_cmpa_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq_cmpa[1] |-> $past(ie_a1));
  a_r6_cmpb_needs_en: assert property (@(posedge clk) disable iff (rst)
    irq_cmpb[1] |-> $past(ie_b1));

  // R8: a wrap pulse leaves the counter at zero unless software wrote it
  a_r8_ovf_lands_zero: assert property (@(posedge clk) disable iff (rst)
    (irq_ovf[1] && !$past(cnt_we[1])) |-> (cnt1 == 8'h00));

  // R9: the low channel is silent while joined
  a_r9_low_silent: assert property (@(posedge clk) disable iff (rst)
    $past(casc) |-> (irq_cmpa[1] == 1'b0 && irq_cmpb[1] == 1'b0 && irq_ovf[1] == 1'b0));
endmodule

bind dual_cmp_timer dct_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_wide (bus_wide),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .irq_cmpa (irq_cmpa),
  .irq_cmpb (irq_cmpb),
  .irq_ovf  (irq_ovf),
  .casc     (casc),
  .ie_a1    (ctrl_q[1].ie_a),
  .ie_b1    (ctrl_q[1].ie_b),
  .psel0    (clkc_q[0].psel),
  .cnt0     (cnt_q[0]),
  .cnt1     (cnt_q[1]),
  .cnt_we   (cnt_we)
);

// File: tb/dual_cmp_timer_tb.sv
`timescale 1ns/1ps
module dual_cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_wide = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  irq_cmpa, irq_cmpb, irq_ovf;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_cmp_timer u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
  );

  // ---------------- behavioural reference model ----------------
  int m_ctrl[2], m_stat[2], m_cmpa[2], m_cmpb[2], m_cnt[2], m_clk[2], m_div[2];
  int m_rd;
  bit m_ia[2], m_ib[2], m_io[2];

  function automatic int divof(int s);
    case (s)
      1: return 1;    2: return 2;    3: return 8;     4: return 32;
      5: return 64;   6: return 1024; 7: return 8192;  default: return 0;
    endcase
  endfunction

  function automatic int view(int ch, int r);
    case (r)
      0: return m_ctrl[ch];
      1: return m_stat[ch];
      2: return m_cmpa[ch];
      3: return m_cmpb[ch];
      4: return m_cnt[ch];
      5: return m_clk[ch];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : mdl
    int nc[2]; bit tk[2]; bit restart[2]; bit casc;
    int v, ca, cb, cm, r, ch, val; bit bad;
    if (rst) begin
      for (int k = 0; k < 2; k++) begin
        m_ctrl[k] = 0; m_cmpa[k] = 255; m_cmpb[k] = 255; m_cnt[k] = 0;
        m_clk[k] = 0; m_div[k] = 0; m_ia[k] = 0; m_ib[k] = 0; m_io[k] = 0;
      end
      m_stat[0] = 0; m_stat[1] = 'h10; m_rd = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        int s;
        s = m_clk[k] & 7;
        tk[k] = (s != 0) && ((m_div[k] % divof(s)) == 0);
        nc[k] = m_cnt[k]; restart[k] = 0;
        m_ia[k] = 0; m_ib[k] = 0; m_io[k] = 0;
      end
      casc = ((m_clk[0] >> 3) & 3) == 3;
      if (casc) begin
        if (((m_clk[1] >> 3) & 3) == 1 && tk[1]) begin
          v  = m_cnt[0] * 256 + m_cnt[1];
          ca = m_cmpa[0] * 256 + m_cmpa[1];
          cb = m_cmpb[0] * 256 + m_cmpb[1];
          cm = (m_ctrl[0] >> 3) & 3;
          m_ia[0] = (v == ca) && m_ctrl[0][6];
          m_ib[0] = (v == cb) && m_ctrl[0][7];
          m_io[0] = (v == 65535) && m_ctrl[0][5];
          if ((cm == 1 && v == ca) || (cm == 2 && v == cb)) v = 0;
          else v = (v + 1) & 65535;
          nc[0] = v >> 8; nc[1] = v & 255;
        end
      end else begin
        for (int k = 0; k < 2; k++) begin
          if (((m_clk[k] >> 3) & 3) == 1 && tk[k]) begin
            v = m_cnt[k]; cm = (m_ctrl[k] >> 3) & 3;
            m_ia[k] = (v == m_cmpa[k]) && m_ctrl[k][6];
            m_ib[k] = (v == m_cmpb[k]) && m_ctrl[k][7];
            m_io[k] = (v == 255) && m_ctrl[k][5];
            if ((cm == 1 && v == m_cmpa[k]) || (cm == 2 && v == m_cmpb[k])) v = 0;
            else v = (v + 1) & 255;
            nc[k] = v;
          end
        end
      end
      if (bus_sel) begin
        r = int'(bus_addr[3:1]); ch = int'(bus_addr[0]);
        bad = bus_wide && (ch == 1 || r < 2 || r > 5);
        if (!bus_wr) begin
          if (bad) m_rd = 'hFFFF;
          else if (bus_wide) m_rd = view(0, r) * 256 + view(1, r);
          else m_rd = view(ch, r);
        end else if (!bad) begin
          for (int k = 0; k < 2; k++) begin
            if (bus_wide || ch == k) begin
              val = bus_wide ? (k == 0 ? int'(bus_wdata[15:8]) : int'(bus_wdata[7:0]))
                             : int'(bus_wdata[7:0]);
              case (r)
                0: m_ctrl[k] = val & 'hF8;
                1: m_stat[k] = (k == 0) ? (val & 'h3F) : ((val & 'h0F) | 'h10);
                2: m_cmpa[k] = val;
                3: m_cmpb[k] = val;
                4: nc[k] = val;
                5: begin m_clk[k] = val & 'h9F; restart[k] = 1; end
                default: ;
              endcase
            end
          end
        end
      end
      for (int k = 0; k < 2; k++) begin
        m_cnt[k] = nc[k];
        m_div[k] = restart[k] ? 0 : ((m_div[k] + 1) & 8191);
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if (bus_rdata !== 16'(m_rd)) begin
        errors++; $display("FAIL R2 rdata act=%h exp=%h", bus_rdata, 16'(m_rd));
      end
      for (int k = 0; k < 2; k++) begin
        checks += 3;
        if (irq_cmpa[k] !== m_ia[k]) begin
          errors++; $display("FAIL R6 irq_cmpa[%0d] act=%b exp=%b", k, irq_cmpa[k], m_ia[k]);
        end
        if (irq_cmpb[k] !== m_ib[k]) begin
          errors++; $display("FAIL R6 irq_cmpb[%0d] act=%b exp=%b", k, irq_cmpb[k], m_ib[k]);
        end
        if (irq_ovf[k] !== m_io[k]) begin
          errors++; $display("FAIL R8 irq_ovf[%0d] act=%b exp=%b", k, irq_ovf[k], m_io[k]);
        end
      end
    end
  end

  // pulse tallies
  int pa[2], pb[2], po[2];
  int wa[2], wb[2], wo[2];
  initial for (int k = 0; k < 2; k++) begin pa[k] = 0; pb[k] = 0; po[k] = 0; end
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      pa[k] += int'(irq_cmpa[k]); pb[k] += int'(irq_cmpb[k]); po[k] += int'(irq_ovf[k]);
    end
  end

  // ---------------- tasks (called just after a falling edge) ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++; $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d, bit wide = 0);
    bus_sel = 1; bus_wr = 1; bus_wide = wide; bus_addr = 4'(a); bus_wdata = 16'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_wide = 0;
  endtask

  task automatic rd(string tag, int a, int exp, bit wide = 0);
    bus_sel = 1; bus_wr = 0; bus_wide = wide; bus_addr = 4'(a);
    @(negedge clk);
    bus_sel = 0; bus_wide = 0;
    chk(tag, int'(bus_rdata), exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic win(int n);
    int sa[2], sb[2], so[2];
    #1;
    for (int k = 0; k < 2; k++) begin sa[k] = pa[k]; sb[k] = pb[k]; so[k] = po[k]; end
    repeat (n) @(negedge clk);
    #1;
    for (int k = 0; k < 2; k++) begin
      wa[k] = pa[k] - sa[k]; wb[k] = pb[k] - sb[k]; wo[k] = po[k] - so[k];
    end
  endtask

  initial begin : watchdog
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R1 reset state
    rd("R1 ctrl0", 'h0, 'h00);
    rd("R1 stat0", 'h2, 'h00);
    rd("R1 stat1", 'h3, 'h10);
    rd("R1 cmpa0", 'h4, 'hFF);
    rd("R1 cmpb1", 'h7, 'hFF);
    rd("R1 cnt1",  'h9, 'h00);
    rd("R1 clk0",  'hA, 'h00);
    chk("R1 irq idle", int'({irq_cmpa, irq_cmpb, irq_ovf}), 0);

    // R4 illegal wide accesses
    rd("R4 odd wide read",  'h5, 'hFFFF, 1);
    rd("R4 ctrl wide read", 'h0, 'hFFFF, 1);
    rd("R4 stat wide read", 'h2, 'hFFFF, 1);
    wr('h2, 'h3F3F, 1);
    rd("R4 stat0 untouched", 'h2, 'h00);
    rd("R4 stat1 untouched", 'h3, 'h10);
    wr('h9, 'hABCD, 1);
    rd("R4 cnt0 untouched", 'h8, 'h00);
    rd("R4 cnt1 untouched", 'h9, 'h00);

    // R2 byte read-back masks
    wr('h0, 'hFF);  rd("R2 ctrl mask", 'h0, 'hF8);
    wr('hB, 'hFF);  rd("R2 clk mask", 'hB, 'h9F);
    idle(10);       rd("R10 ch1 src3 holds", 'h9, 'h00);
    wr('hB, 'h00);
    wr('h3, 'hFF);  rd("R2 stat1 mask", 'h3, 'h1F);
    wr('h2, 'hFF);  rd("R2 stat0 mask", 'h2, 'h3F);
    wr('h0, 'h00);
    rd("R2 unmapped", 'hC, 'h00);

    // R3 wide accesses
    wr('h4, 'h1234, 1);
    rd("R3 cmpa0 high byte", 'h4, 'h12);
    rd("R3 cmpa1 low byte",  'h5, 'h34);
    rd("R3 wide cmpa", 'h4, 'h1234, 1);
    wr('hA, 'h8000, 1);
    rd("R3 wide clk", 'hA, 'h8000, 1);
    wr('hA, 'h0000, 1);

    // R5 / R7 clear on A, channel 1, divide by 1 then 2
    wr('hB, 'h00); wr('h9, 'h00); wr('h5, 'h05); wr('h1, 'h48); wr('hB, 'h09);
    idle(10); win(60);
    chk("R7 clear-A period div1", wa[1], 10);
    chk("R8 no wrap under clear", wo[1], 0);
    wr('hB, 'h0A);
    idle(20); win(120);
    chk("R5 div2 period", wa[1], 10);
    wr('hB, 'h0B);
    idle(20); win(96);
    chk("R5 div8 period", wa[1], 2);

    // R7 clear on B
    wr('hB, 'h00); wr('h9, 'h00); wr('h7, 'h09); wr('h1, 'h90); wr('hB, 'h09);
    idle(10); win(100);
    chk("R7 clear-B period", wb[1], 10);
    chk("R6 cmpa disabled", wa[1], 0);

    // R11 bus write beats counting
    wr('h9, 'h40);
    rd("R11 counter write wins", 'h9, 'h40);

    // R10 non-internal sources hold
    wr('hB, 'h01); wr('h9, 'h33); idle(20);
    rd("R10 src0 holds", 'h9, 'h33);
    wr('hB, 'h11); idle(20);
    rd("R10 src2 holds", 'h9, 'h33);

    // R8 overflow channel 0
    wr('hA, 'h00); wr('h8, 'h00); wr('h4, 'hFF); wr('h0, 'h20); wr('hA, 'h09);
    idle(5); win(512);
    chk("R8 wrap count", wo[0], 2);
    chk("R6 enable off no cmpa", wa[0], 0);

    // R9 cascade: 16-bit compare 300 with clear on A
    wr('hA, 'h00); wr('hB, 'h00);
    wr('h8, 'h0000, 1); wr('h4, 'h012C, 1);
    wr('h0, 'h48); wr('h1, 'h00); wr('hB, 'h09); wr('hA, 'h18);
    idle(10); win(903);
    chk("R9 cascade period", wa[0], 3);
    chk("R9 low channel cmpa silent", wa[1], 0);
    chk("R9 low channel ovf silent", wo[1], 0);

    // R9 cascade overflow at 0xFFFF
    wr('h0, 'h20);
    wr('h8, 'hFFF0, 1);
    win(40);
    chk("R9 cascade wrap", wo[0], 1);
    chk("R9 low channel quiet on wrap", wo[1], 0);

    idle(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule